// File: doc/BRIEF.md
# Register-Programmed Watchdog with Frequency-Source Recovery

This block is a seconds-resolution watchdog for the control path of a clock generator. A host writes one small control word through a single-cycle write port. The word holds a timeout field, a reload bit and a recovery-mode bit. A one-cycle seconds tick, synchronous to the block clock, advances an elapsed-time counter. When the counter reaches the programmed period, the block does three things:

- it sets a sticky alarm flag;
- it issues a one-cycle restore request;
- it drives a frequency-source select that names the setting to fall back to.

The fallback is either the hardware-strapped frequency selection or the last software-programmed one.

The timeout field counts in units of two seconds, so the period is the field value times two ticks. Writing zero to the field switches the watchdog off, and it is also the only way to drop the alarm. A reload restarts the count and the watchdog keeps running. It acts only when the reload bit changes from 0 to 1. After expiry the counter holds, and no further requests are made until software reloads, reprograms or clears the watchdog. Frequency synthesis, the serial bus that carries the writes and the divider arithmetic live outside this block.

Top module: `wdg_recover`

## Requirements
- R1: After reset the alarm, the restore request and the frequency-source select are 0, and the stored timeout field, reload bit and recovery bit are 0. The control word is written when `cfg_we` is 1. Its encoding is: bits [3:0] timeout field, bit [4] reload, bit [5] recovery mode.
- R2: While the stored timeout field is 0000 the watchdog is off: ticks are not counted, and no alarm or restore request is produced.
- R3: With a non-zero field value N, the alarm and restore request appear in the cycle after the clock edge that samples the 2×N-th tick since counting began. N=1 gives 2 ticks and N=15 gives 30 ticks.
- R4: A reload happens only on a write whose reload bit is 1 while the stored reload bit is 0. Rewriting 1 over a stored 1 does not restart the count.
- R5: A reload clears the elapsed count and counting continues, so expiry follows 2×N ticks after the reload. A reload does not clear the alarm.
- R6: The alarm, once set, stays 1 until a write stores 0000 in the timeout field. That write clears it at the next edge.
- R7: On expiry `freq_src_o` takes the stored recovery bit: 0 selects the hardware-strapped setting and 1 the last software setting. It holds that value until the next expiry.
- R8: Writing a non-zero timeout value different from the stored one restarts the count from zero. Rewriting the same value does not.
- R9: After expiry the counter holds: further ticks give no further restore requests until a reload, a new period or a clear.
- R10: The restore request is exactly one cycle wide for each expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word: [3:0] timeout, [4] reload, [5] recovery mode |
| sec_tick | input | 1 | One-cycle seconds pulse, synchronous to clk |
| alarm_o | output | 1 | Sticky expiry flag |
| restore_req_o | output | 1 | One-cycle restore request on expiry |
| freq_src_o | output | 1 | Frequency source to restore: 0 hardware strap, 1 last software |

## Verification
The bench covers several corner cases, each aimed at a specific wrong design:
- It holds the reload bit at 1 across two writes. A design that reacted to the level rather than the edge would push expiry late.
- It rewrites the same period in mid-count. A design that restarted on any write would also expire late.
- It shortens the period in mid-count. A design that did not restart would expire at once.
- It keeps ticking after expiry. A design that did not hold the counter would repeat restore requests.
- It reloads while the alarm is set. A design that cleared the alarm on any event other than a zero timeout would lose the sticky flag.
- It runs the shortest and the longest periods and flips the recovery bit between runs, to catch miscounted limits and a wrong source select.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // width of the timeout field and ticks per field unit
  localparam int TO_W = 4;
  localparam int TICKS_PER_UNIT = 2;
  // control word layout: [TO_W-1:0] timeout, [TO_W] reload, [TO_W+1] recovery
  localparam int CFG_W = TO_W + 2;

  typedef struct packed {
    logic            recov;
    logic            reload;
    logic [TO_W-1:0] timeout;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_ctrl_regs.sv
module wdg_ctrl_regs
  import wdg_pkg::*;
#(
  parameter int TW = TO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [TW-1:0] wr_timeout,
  input  logic          wr_reload,
  input  logic          wr_recov,
  output logic [TW-1:0] timeout_q,
  output logic          recov_q,
  output logic          restart,
  output logic          clear_off
);
  logic reload_q;
  logic reload_rise;
  logic new_period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout_q <= '0;
      reload_q  <= 1'b0;
      recov_q   <= 1'b0;
    end else if (cfg_we) begin
      timeout_q <= wr_timeout;
      reload_q  <= wr_reload;
      recov_q   <= wr_recov;
    end
  end

  always_comb begin
    reload_rise = cfg_we && wr_reload && !reload_q;
    new_period  = cfg_we && (wr_timeout != '0) && (wr_timeout != timeout_q);
    clear_off   = cfg_we && (wr_timeout == '0);
    restart     = reload_rise || new_period;
  end

  // R4: a held reload bit with an unchanged period never restarts the count
  a_r4_level_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_reload && reload_q && (wr_timeout == timeout_q)) |-> !restart);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int TW   = TO_W,
  parameter int STEP = TICKS_PER_UNIT,
  localparam int CNT_W = $clog2(((1 << TW) - 1) * STEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [TW-1:0] timeout_q,
  input  logic          restart,
  input  logic          clear_off,
  output logic          expire_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit;
  logic             expired;
  logic             running;

  always_comb begin
    limit      = CNT_W'(timeout_q) * CNT_W'(STEP);
    cnt_inc    = cnt + CNT_W'(1);
    running    = (timeout_q != '0) && !expired && !restart && !clear_off;
    expire_evt = running && tick && (cnt_inc == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_off || restart) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (running && tick) begin
      cnt     <= cnt_inc;
      expired <= expire_evt;
    end
  end

  // R2: an off watchdog keeps an empty count
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q == '0) |-> (cnt == '0 && !expired));
  // R3: the count never passes the programmed limit
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q != '0) |-> (cnt <= limit));
  // R9: after expiry the count holds until reload, new period or clear
  a_r9_hold_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart && !clear_off) |=> $stable(cnt));
endmodule

// File: rtl/wdg_action.sv
module wdg_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic recov_q,
  input  logic clear_off,
  output logic alarm_q,
  output logic restore_q,
  output logic fsrc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q   <= 1'b0;
      restore_q <= 1'b0;
      fsrc_q    <= 1'b0;
    end else begin
      restore_q <= expire_evt;
      if (expire_evt) begin
        alarm_q <= 1'b1;
        fsrc_q  <= recov_q;
      end else if (clear_off) begin
        alarm_q <= 1'b0;
      end
    end
  end

  // R10: one-cycle restore request
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |=> !restore_q);
  // R6: alarm only drops on a zero-timeout write
  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !clear_off) |=> alarm_q);
  // R7: source select follows the recovery bit held at expiry
  a_r7_source_select: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |-> (fsrc_q == $past(recov_q)));
  // R3: a restore request always comes with the alarm
  a_r3_alarm_with_restore: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |-> alarm_q);
endmodule

// File: rtl/wdg_recover.sv
module wdg_recover
  import wdg_pkg::*;
#(
  parameter int TW   = TO_W,
  parameter int STEP = TICKS_PER_UNIT,
  localparam int CW  = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          sec_tick,
  output logic          alarm_o,
  output logic          restore_req_o,
  output logic          freq_src_o
);
  logic [TW-1:0] timeout_q;
  logic          recov_q;
  logic          restart;
  logic          clear_off;
  logic          expire_evt;

  wdg_ctrl_regs #(.TW(TW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .wr_timeout (cfg_wdata[TW-1:0]),
    .wr_reload  (cfg_wdata[TW]),
    .wr_recov   (cfg_wdata[TW+1]),
    .timeout_q  (timeout_q),
    .recov_q    (recov_q),
    .restart    (restart),
    .clear_off  (clear_off)
  );

  wdg_counter #(.TW(TW), .STEP(STEP)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sec_tick),
    .timeout_q  (timeout_q),
    .restart    (restart),
    .clear_off  (clear_off),
    .expire_evt (expire_evt)
  );

  wdg_action u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_evt (expire_evt),
    .recov_q    (recov_q),
    .clear_off  (clear_off),
    .alarm_q    (alarm_o),
    .restore_q  (restore_req_o),
    .fsrc_q     (freq_src_o)
  );

  // R2: with the watchdog off nothing is requested
  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q == '0) |=> !restore_req_o);
endmodule

// File: tb/tb_wdg_recover.sv
module tb_wdg_recover;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       sec_tick = 1'b0;
  logic       alarm_o, restore_req_o, freq_src_o;

  always #10 clk = ~clk;

  wdg_recover dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sec_tick(sec_tick), .alarm_o(alarm_o), .restore_req_o(restore_req_o),
    .freq_src_o(freq_src_o)
  );

  typedef struct {
    logic  alarm;
    logic  restore;
    logic  fsrc;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state from the requirements
  logic [3:0] m_to = 0;
  logic       m_rel = 0, m_rec = 0, m_exp = 0, m_alarm = 0, m_fsrc = 0;
  int         m_cnt = 0;

  task automatic step(input logic we, input logic [5:0] d, input logic tk);
    exp_t e;
    logic rst_evt, clr, rs;
    @(negedge clk);
    cfg_we = we; cfg_wdata = d; sec_tick = tk;
    rs = 0;
    clr = we && (d[3:0] == 0);
    rst_evt = (we && d[4] && !m_rel) || (we && d[3:0] != 0 && d[3:0] != m_to);
    if (clr) begin
      m_cnt = 0; m_exp = 0; m_alarm = 0;
    end else if (rst_evt) begin
      m_cnt = 0; m_exp = 0;
    end else if (tk && m_to != 0 && !m_exp) begin
      m_cnt++;
      if (m_cnt == 2 * m_to) begin
        m_exp = 1; m_alarm = 1; rs = 1; m_fsrc = m_rec;
      end
    end
    if (we) begin
      m_to = d[3:0]; m_rel = d[4]; m_rec = d[5];
    end
    e.alarm = m_alarm; e.restore = rs; e.fsrc = m_fsrc; e.req = cur_req;
    sb.push_back(e);
  endtask

  task automatic wr(input logic rec, input logic rel, input logic [3:0] to);
    step(1'b1, {rec, rel, to}, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 6'd0, 1'b1);
      step(1'b0, 6'd0, 1'b0);
    end
  endtask

  // monitor: compares each cycle's outputs against the scoreboard
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (alarm_o !== e.alarm || restore_req_o !== e.restore || freq_src_o !== e.fsrc) begin
        n_bad++;
        $display("FAIL %s: alarm/restore/src actual %b%b%b expected %b%b%b",
                 e.req, alarm_o, restore_req_o, freq_src_o, e.alarm, e.restore, e.fsrc);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_bad++;
          $display("FAIL watchdog: actual hung expected finish");
          $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    step(0, 0, 0); step(0, 0, 0);
    // R2: off, ticks ignored
    cur_req = "R2";
    ticks(40);
    // R3: shortest period, hardware source
    cur_req = "R3";
    wr(0, 0, 4'd1);
    ticks(2);
    // R9/R10: holding after expiry
    cur_req = "R9";
    ticks(5);
    // R5/R6: reload restarts, alarm kept
    cur_req = "R5";
    wr(0, 1, 4'd1);
    ticks(2);
    // R4: level reload does nothing
    cur_req = "R4";
    wr(0, 0, 4'd1);
    wr(0, 1, 4'd1);   // rising: restart
    ticks(1);
    wr(0, 1, 4'd1);   // held: no restart
    ticks(1);         // expires here
    step(0, 0, 0);
    // R6: clear on zero write
    cur_req = "R6";
    wr(0, 0, 4'd0);
    ticks(3);
    // R7: software source
    cur_req = "R7";
    wr(1, 0, 4'd3);
    ticks(6);
    wr(0, 0, 4'd0);
    // R8: rewriting same value keeps count, new value restarts
    cur_req = "R8";
    wr(1, 0, 4'd15);
    ticks(10);
    wr(1, 0, 4'd15);
    ticks(4);
    wr(0, 0, 4'd2);
    ticks(4);
    wr(0, 0, 4'd0);
    // R3: longest period
    cur_req = "R3";
    wr(1, 0, 4'd15);
    ticks(29);
    step(0, 0, 0);
    ticks(1);
    // R10: one pulse only
    cur_req = "R10";
    ticks(3);
    step(0, 0, 0); step(0, 0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule